// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds the chip's power-mode state and turns it into clock gating and a system clock divider. Software writes three fields together: a two-bit mode field, a clock-source select bit that picks the reduced-speed "gear" variant, and a timer-keep bit that qualifies the deepest mode. From these the block decodes one of seven operating modes. It drives enables for the core, for the extended execution units, for the system clock and for the timer domain (real-time clock, periodic timer, time base, decrementer).

The system clock is given as a one-cycle enable pulse. The pulse comes once every 2^E cycles, where E is the high-divider field in the full-speed variants and the low-divider field plus one in the gear variants. Wake-up events are asynchronous: the interrupt controller's wake request, three timer interrupts that are each qualified by an enable, and a decrementer exception. Each passes a two-flop synchronizer. An enabled event then forces the mode field back to running while the gear select and the timer-keep bit keep their values.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode field is 00, the gear bit and the timer-keep bit are 0, and modeStatus reads 0 (normal-high).
- R2: modeStatus encodes the mode as follows: mode field 00 gives 0 (gear 0) or 1 (gear 1). Field 01 gives 2 (gear 0) or 3 (gear 1). Field 10 gives 4 (sleep). Field 11 gives 5 when timer-keep is 1 (deep-sleep) and 6 when it is 0 (power-down).
- R3: In modes 0 and 1 the core, extended-unit, system and timer enables are all active.
- R4: In modes 2 and 3 the core and extended-unit enables are off, and the system clock pulses and the timer enable stay on.
- R5: In mode 4 the core, extended-unit and system clock enables are off, and the timer enable is on.
- R6: In mode 5 only the timer enable is on. In mode 6 every enable output is off.
- R7: divExp equals divHigh when gear is 0 and divLow+1 when gear is 1. In modes 0 to 3, sysClkEn pulses exactly 2^(2^DIV_W - divExp) times in any window of 2^(2^DIV_W) consecutive cycles.
- R8: A write is visible on modeField, gearLow, timerKeep and modeStatus right after the clock edge that samples wrEn.
- R9: A wake source held high from before rising edge k clears the mode field to 00 at edge k+2. At edge k+1 the mode is still unchanged. gearLow and timerKeep keep their values.
- R10: A timer interrupt whose enable bit is 0 does not wake the block.
- R11: When a wake and a write land on the same edge, the mode field becomes 00 and the gear and timer-keep bits take the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Software write strobe for the three mode fields |
| wrModeField | input | 2 | Mode field to write (00 normal, 01 doze, 10 sleep, 11 deepest) |
| wrGearLow | input | 1 | Gear (low-speed variant) select to write |
| wrTimerKeep | input | 1 | Timer-keep bit to write (1 deep-sleep, 0 power-down) |
| divHigh | input | DIV_W | Divider exponent for the full-speed variants |
| divLow | input | DIV_W | Divider exponent minus one for the gear variants |
| wakeIc | input | 1 | Asynchronous wake request from the interrupt controller |
| timerIrq | input | NUM_TMR | Asynchronous timer interrupts (real-time clock, periodic, time base) |
| timerIrqEn | input | NUM_TMR | Per-timer wake enables |
| decExc | input | 1 | Asynchronous decrementer exception |
| coreClkEn | output | 1 | Core clock enable |
| extClkEn | output | 1 | Extended execution unit clock enable |
| sysClkEn | output | 1 | Divided system clock enable pulse |
| timerClkEn | output | 1 | Timer domain clock enable |
| divExp | output | DIV_W+1 | Divider exponent currently selected |
| modeStatus | output | 3 | Decoded mode |
| modeField | output | 2 | Mode field readback |
| gearLow | output | 1 | Gear select readback |
| timerKeep | output | 1 | Timer-keep readback |

## Verification
The bench builds the block with DIV_W = 3 and NUM_TMR = 3. With these values the free-running divide counter is eight bits and repeats every 256 cycles, so each of the eight divider values in all four running variants can be swept. The pulse count over one full counter period then has an exact expected value. All sixteen combinations of the three writable fields are applied. Each of the five wake sources is stepped edge by edge through the synchronizer to pin down its latency.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    MODE_NORM_HI  = 3'd0,
    MODE_NORM_LO  = 3'd1,
    MODE_DOZE_HI  = 3'd2,
    MODE_DOZE_LO  = 3'd3,
    MODE_SLEEP    = 3'd4,
    MODE_DEEP     = 3'd5,
    MODE_PDOWN    = 3'd6
  } pmMode_e;

  typedef struct packed {
    pmMode_e mode;
    logic    coreRun;
    logic    sysRun;
    logic    timerRun;
    logic    gearLow;
  } pmStrobe_t;

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end

endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_TMR = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrModeField,
  input  logic               wrGearLow,
  input  logic               wrTimerKeep,
  input  logic               wakeIc,
  input  logic [NUM_TMR-1:0] timerIrq,
  input  logic [NUM_TMR-1:0] timerIrqEn,
  input  logic               decExc,
  output logic [1:0]         modeField,
  output logic               gearLow,
  output logic               timerKeep,
  output pmStrobe_t          strobe
);

  localparam int SRC_W = NUM_TMR + 2;

  logic [SRC_W-1:0]   rawSrc;
  logic [SRC_W-1:0]   syncSrc;
  logic [NUM_TMR-1:0] tmrHit;
  logic               wakeHit;
  pmMode_e            modeNow;

  assign rawSrc = {decExc, timerIrq, wakeIc};

  pmc_sync #(.WIDTH(SRC_W)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawSrc),
    .syncOut (syncSrc)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : gTmrMask
    assign tmrHit[i] = syncSrc[i+1] & timerIrqEn[i];
  end

  assign wakeHit = syncSrc[0] | syncSrc[SRC_W-1] | (|tmrHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeField <= 2'b00;
      gearLow   <= 1'b0;
      timerKeep <= 1'b0;
    end else begin
      if (wrEn) begin
        modeField <= wrModeField;
        gearLow   <= wrGearLow;
        timerKeep <= wrTimerKeep;
      end
      if (wakeHit) modeField <= 2'b00;
    end
  end

  always_comb begin
    case (modeField)
      2'b00:   modeNow = gearLow ? MODE_NORM_LO : MODE_NORM_HI;
      2'b01:   modeNow = gearLow ? MODE_DOZE_LO : MODE_DOZE_HI;
      2'b10:   modeNow = MODE_SLEEP;
      default: modeNow = timerKeep ? MODE_DEEP : MODE_PDOWN;
    endcase
  end

  always_comb begin
    strobe.mode     = modeNow;
    strobe.gearLow  = gearLow;
    strobe.coreRun  = (modeField == 2'b00);
    strobe.sysRun   = (modeField == 2'b00) || (modeField == 2'b01);
    strobe.timerRun = (modeNow != MODE_PDOWN);
  end

  // R9: an enabled, synchronized wake forces the running mode field
  a_r9_wake_clears: assert property (@(posedge clk) disable iff (!rstN)
    wakeHit |=> modeField == 2'b00);

  // R9: wake leaves the gear and timer-keep bits alone
  a_r9_bits_kept: assert property (@(posedge clk) disable iff (!rstN)
    (wakeHit && !wrEn) |=> ($stable(gearLow) && $stable(timerKeep)));

  // R8: a write without wake lands on the next edge
  a_r8_write_next: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wakeHit) |=> modeField == $past(wrModeField));

  // R11: write and wake together keep the written qualifier bits
  a_r11_write_wake: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wakeHit) |=> (modeField == 2'b00 && gearLow == $past(wrGearLow)
                           && timerKeep == $past(wrTimerKeep)));

endmodule

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  pmStrobe_t        strobe,
  input  logic [DIV_W-1:0] divHigh,
  input  logic [DIV_W-1:0] divLow,
  output logic             coreClkEn,
  output logic             extClkEn,
  output logic             sysClkEn,
  output logic             timerClkEn,
  output logic [DIV_W:0]   divExp
);

  localparam int EXP_W = DIV_W + 1;
  localparam int CNT_W = 1 << DIV_W;

  logic [CNT_W-1:0] divCnt;
  logic [EXP_W-1:0] expSel;
  logic [CNT_W:0]   spanMask;

  assign expSel = strobe.gearLow ? (EXP_W'(divLow) + EXP_W'(1)) : EXP_W'(divHigh);
  assign spanMask = ({{CNT_W{1'b0}}, 1'b1} << expSel) - 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  assign divExp     = expSel;
  assign sysClkEn   = strobe.sysRun && ((divCnt & spanMask[CNT_W-1:0]) == '0);
  assign coreClkEn  = strobe.coreRun;
  assign extClkEn   = strobe.coreRun;
  assign timerClkEn = strobe.timerRun;

  // R6: power-down gates everything
  a_r6_pdown_dark: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == MODE_PDOWN) |-> !(coreClkEn || extClkEn || sysClkEn || timerClkEn));

  // R5: sleep keeps the timer domain but stops the core and system clock
  a_r5_sleep_timer: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == MODE_SLEEP) |-> (timerClkEn && !coreClkEn && !sysClkEn));

  // R3: core runs only in the normal variants
  a_r3_core_normal: assert property (@(posedge clk) disable iff (!rstN)
    coreClkEn |-> (strobe.mode == MODE_NORM_HI || strobe.mode == MODE_NORM_LO));

  // R7: exponent zero means a pulse on every cycle while the system clock runs
  a_r7_full_rate: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sysRun && divExp == '0) |-> sysClkEn);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int DIV_W   = 3,
  parameter int NUM_TMR = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrModeField,
  input  logic               wrGearLow,
  input  logic               wrTimerKeep,
  input  logic [DIV_W-1:0]   divHigh,
  input  logic [DIV_W-1:0]   divLow,
  input  logic               wakeIc,
  input  logic [NUM_TMR-1:0] timerIrq,
  input  logic [NUM_TMR-1:0] timerIrqEn,
  input  logic               decExc,
  output logic               coreClkEn,
  output logic               extClkEn,
  output logic               sysClkEn,
  output logic               timerClkEn,
  output logic [DIV_W:0]     divExp,
  output logic [2:0]         modeStatus,
  output logic [1:0]         modeField,
  output logic               gearLow,
  output logic               timerKeep
);

  pmStrobe_t strobe;

  pmc_ctrl #(.NUM_TMR(NUM_TMR)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrModeField (wrModeField),
    .wrGearLow   (wrGearLow),
    .wrTimerKeep (wrTimerKeep),
    .wakeIc      (wakeIc),
    .timerIrq    (timerIrq),
    .timerIrqEn  (timerIrqEn),
    .decExc      (decExc),
    .modeField   (modeField),
    .gearLow     (gearLow),
    .timerKeep   (timerKeep),
    .strobe      (strobe)
  );

  pmc_datapath #(.DIV_W(DIV_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .divHigh    (divHigh),
    .divLow     (divLow),
    .coreClkEn  (coreClkEn),
    .extClkEn   (extClkEn),
    .sysClkEn   (sysClkEn),
    .timerClkEn (timerClkEn),
    .divExp     (divExp)
  );

  assign modeStatus = strobe.mode;

endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;

  localparam int DIV_W   = 3;
  localparam int NUM_TMR = 3;
  localparam int PERIOD  = 1 << (1 << DIV_W);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rstN;
  logic               wrEn;
  logic [1:0]         wrModeField;
  logic               wrGearLow;
  logic               wrTimerKeep;
  logic [DIV_W-1:0]   divHigh;
  logic [DIV_W-1:0]   divLow;
  logic               wakeIc;
  logic [NUM_TMR-1:0] timerIrq;
  logic [NUM_TMR-1:0] timerIrqEn;
  logic               decExc;
  logic               coreClkEn, extClkEn, sysClkEn, timerClkEn;
  logic [DIV_W:0]     divExp;
  logic [2:0]         modeStatus;
  logic [1:0]         modeField;
  logic               gearLow, timerKeep;

  pwr_mode_ctrl #(.DIV_W(DIV_W), .NUM_TMR(NUM_TMR)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrModeField(wrModeField),
    .wrGearLow(wrGearLow), .wrTimerKeep(wrTimerKeep), .divHigh(divHigh),
    .divLow(divLow), .wakeIc(wakeIc), .timerIrq(timerIrq),
    .timerIrqEn(timerIrqEn), .decExc(decExc), .coreClkEn(coreClkEn),
    .extClkEn(extClkEn), .sysClkEn(sysClkEn), .timerClkEn(timerClkEn),
    .divExp(divExp), .modeStatus(modeStatus), .modeField(modeField),
    .gearLow(gearLow), .timerKeep(timerKeep)
  );

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expStatus(int mf, int g, int t);
    case (mf)
      0: return g;
      1: return 2 + g;
      2: return 4;
      default: return t ? 5 : 6;
    endcase
  endfunction

  task automatic swWrite(int mf, int g, int t);
    @(negedge clk);
    wrEn = 1'b1;
    wrModeField = 2'(mf);
    wrGearLow = 1'(g);
    wrTimerKeep = 1'(t);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkEnables(int st);
    // R3 R4 R5 R6: enable pattern per decoded mode
    check("R3/R4 core enable", int'(coreClkEn), int'(st < 2));
    check("R3/R4 ext enable", int'(extClkEn), int'(st < 2));
    check("R6 timer enable", int'(timerClkEn), int'(st != 6));
    if (st >= 4) check("R5 system clock stopped", int'(sysClkEn), 0);
  endtask

  task automatic countTicks(output int n);
    n = 0;
    for (int c = 0; c < PERIOD; c++) begin
      @(negedge clk);
      n += int'(sysClkEn);
    end
  endtask

  task automatic wakeStep(int src, int st0, int stWake, int gExp, int tExp);
    @(negedge clk);
    case (src)
      0: wakeIc = 1'b1;
      4: decExc = 1'b1;
      default: timerIrq[src-1] = 1'b1;
    endcase
    @(negedge clk);
    @(negedge clk);
    check("R9 still asleep after two edges", int'(modeStatus), st0);
    @(negedge clk);
    check("R9 mode after wake", int'(modeStatus), stWake);
    check("R9 field cleared", int'(modeField), 0);
    check("R9 gear kept", int'(gearLow), gExp);
    check("R9 timer-keep kept", int'(timerKeep), tExp);
    wakeIc = 1'b0;
    decExc = 1'b0;
    timerIrq = '0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int ticks;
    rstN = 1'b0; wrEn = 1'b0; wrModeField = '0; wrGearLow = 1'b0;
    wrTimerKeep = 1'b0; divHigh = '0; divLow = '0; wakeIc = 1'b0;
    timerIrq = '0; timerIrqEn = '0; decExc = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 status", int'(modeStatus), 0);
    check("R1 mode field", int'(modeField), 0);
    check("R1 gear", int'(gearLow), 0);
    check("R1 timer-keep", int'(timerKeep), 0);
    checkEnables(0);

    // R2 R8: every field combination
    for (int mf = 0; mf < 4; mf++)
      for (int g = 0; g < 2; g++)
        for (int t = 0; t < 2; t++) begin
          swWrite(mf, g, t);
          check("R2 status decode", int'(modeStatus), expStatus(mf, g, t));
          check("R8 mode field readback", int'(modeField), mf);
          check("R8 gear readback", int'(gearLow), g);
          check("R8 timer-keep readback", int'(timerKeep), t);
          checkEnables(expStatus(mf, g, t));
        end

    // R7 R3 R4: divider sweep in the four running variants
    for (int v = 0; v < 4; v++)
      for (int d = 0; d < (1 << DIV_W); d++) begin
        int e;
        divHigh = DIV_W'(d);
        divLow = DIV_W'(d);
        swWrite(v >> 1, v & 1, 0);
        e = (v & 1) ? d + 1 : d;
        check("R7 exponent", int'(divExp), e);
        countTicks(ticks);
        check("R7 pulse count", ticks, PERIOD >> e);
      end

    // R5: no system pulses in sleep over a full period
    swWrite(2, 0, 0);
    countTicks(ticks);
    check("R5 sleep pulse count", ticks, 0);

    // R10: disabled timer interrupts do not wake
    timerIrqEn = '0;
    timerIrq = '1;
    repeat (6) @(negedge clk);
    check("R10 disabled timers ignored", int'(modeStatus), 4);
    timerIrq = '0;
    repeat (4) @(negedge clk);

    // R9: each wake source with edge-exact latency
    timerIrqEn = '1;
    swWrite(1, 1, 0);
    wakeStep(0, 3, 1, 1, 0);
    for (int s = 1; s <= NUM_TMR; s++) begin
      swWrite(2, 1, 1);
      wakeStep(s, 4, 1, 1, 1);
    end
    swWrite(3, 0, 1);
    wakeStep(4, 5, 0, 0, 1);
    swWrite(3, 1, 0);
    wakeStep(4, 6, 1, 1, 0);

    // R11: wake and write on the same edge
    swWrite(1, 0, 0);
    @(negedge clk);
    wakeIc = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wrEn = 1'b1; wrModeField = 2'b10; wrGearLow = 1'b1; wrTimerKeep = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check("R11 mode field", int'(modeField), 0);
    check("R11 gear from write", int'(gearLow), 1);
    check("R11 timer-keep from write", int'(timerKeep), 1);
    check("R11 status", int'(modeStatus), 1);
    wakeIc = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule